// File: doc/BRIEF.md
# Hardware Counting Semaphore

This block is a single shared counting semaphore that guards entry to a critical section for a set of requester ports. Each port raises a valid signal together with a one-bit operation code: take a unit (acquire) or give a unit back (release). The block keeps one unsigned count of free units. At reset the count is loaded with an initial value, and that value is the most requesters that can hold the semaphore together.

The block serves at most one operation per clock cycle, so every update to the count is atomic. Ports that present requests in the same cycle are served in round-robin order. An acquire that finds no free unit is not refused. The port is parked in hardware and must keep its request raised. A later release does not add the unit to the count. It hands the unit straight to one parked port, and parked ports are chosen in round-robin order so that none of them starves. A release that would push the count past its upper limit is reported on a per-port error pulse and has no other effect.

Top module: `hw_sema_unit`

## Requirements
- R1: At reset the free count equals CNT_INIT. No port is parked, and every grant, release-done and release-error output is low.
- R2: A served acquire (op bit 0) with a free count above zero lowers the count by one and raises that port's grant for exactly the next cycle.
- R3: A served acquire with a free count of zero gives no grant and leaves the count at zero. The port is shown as parked from the next cycle on.
- R4: A served release (op bit 1) with no port parked and a count below CNT_MAX raises the count by one and pulses that port's release-done in the next cycle.
- R5: A served release with at least one port parked leaves the count unchanged. In the next cycle the releasing port gets release-done, exactly one parked port gets a grant pulse, and that port is no longer parked.
- R6: The block serves at most one request per cycle. Candidates are the ports that have valid raised, are not parked, and are not being acknowledged in this cycle. The search starts at the port after the one served last (port 0 after reset) and wraps around.
- R7: A parked port is woken by a round-robin search that starts at the port after the one woken last (port 0 after reset).
- R8: A served release with no port parked and the count at CNT_MAX pulses that port's release-error. It gives no release-done and leaves the count unchanged.
- R9: Grant, release-done and release-error are pulses one cycle wide. At most one grant is high in any cycle. A parked port keeps its valid raised until it is granted.
- R10: The free count never goes below zero and never exceeds CNT_MAX, so no more than CNT_INIT requesters hold units at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request raised, one bit per port |
| req_op | input | N_PORTS | Operation per port: 0 acquire, 1 release |
| grant_o | output | N_PORTS | One-cycle pulse: the port now holds a unit |
| rel_done_o | output | N_PORTS | One-cycle pulse: the port's release was accepted |
| rel_err_o | output | N_PORTS | One-cycle pulse: the port's release would overflow and was dropped |
| parked_o | output | N_PORTS | The port is waiting for a unit |
| count_o | output | $clog2(CNT_MAX+1) | Current free count |

## Verification
The assertions assume that requesters follow the handshake. A parked port holds its acquire request raised until its grant arrives. Any other port lowers valid in the cycle it sees its pulse, or at the latest lets the acknowledge mask hide it. Releases are not checked against the set of current holders, so a release from a port that holds nothing is still counted. The stimulus table obeys the handshake row by row: parked ports keep their bits set and acknowledged ports drop theirs. It also uses unmatched releases on purpose, to drive the count up to its ceiling and into the overflow case.

// File: rtl/sema_pkg.sv
package sema_pkg;

  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } sema_op_e;

  typedef enum logic [2:0] {
    EV_IDLE    = 3'd0,
    EV_TAKE    = 3'd1,
    EV_PARK    = 3'd2,
    EV_HANDOFF = 3'd3,
    EV_FREE    = 3'd4,
    EV_OVFL    = 3'd5
  } sema_ev_e;

  // Decide what the one operation served this cycle does.
  function automatic sema_ev_e sema_classify(
    input logic     hit,
    input sema_op_e op,
    input logic     cnt_zero,
    input logic     has_waiter,
    input logic     cnt_full
  );
    if (!hit)               return EV_IDLE;
    if (op == OP_ACQ)       return cnt_zero ? EV_PARK : EV_TAKE;
    if (has_waiter)         return EV_HANDOFF;
    if (cnt_full)           return EV_OVFL;
    return EV_FREE;
  endfunction

endpackage

// File: rtl/sema_rr_pick.sv
module sema_rr_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] ptr_q;

  // First requesting position at or after the pointer, wrapping.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int pos;
      pos = (int'(ptr_q) + k) % N;
      if (!found && req[pos]) begin
        found = 1'b1;
        idx   = IDX_W'(pos);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance && found) begin
      ptr_q <= (int'(idx) == N - 1) ? '0 : idx + IDX_W'(1);
    end
  end

  p_pick_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[idx]);
  p_pick_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> found);

endmodule

// File: rtl/sema_count_reg.sv
module sema_count_reg
  import sema_pkg::*;
#(
  parameter int CNT_MAX  = 7,
  parameter int CNT_INIT = 2,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sema_ev_e         ev,
  output logic [CNT_W-1:0] count,
  output logic             is_zero,
  output logic             is_full
);

  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL_V = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(CNT_INIT);

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input sema_ev_e e);
    case (e)
      EV_TAKE: return c - ONE;
      EV_FREE: return c + ONE;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= INIT_V;
    else        count_q <= cnt_step(count_q, ev);
  end

  assign count   = count_q;
  assign is_zero = (count_q == '0);
  assign is_full = (count_q == FULL_V);

  p_take_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TAKE) |=> (count_q == $past(count_q) - ONE));
  p_free_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_FREE) |=> (count_q == $past(count_q) + ONE));
  p_handoff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_HANDOFF || ev == EV_PARK) |=> $stable(count_q));
  p_ovfl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_OVFL) |=> $stable(count_q));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_TAKE) |-> !is_zero);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q <= FULL_V));

endmodule

// File: rtl/hw_sema_unit.sv
module hw_sema_unit
  import sema_pkg::*;
#(
  parameter int N_PORTS  = 4,
  parameter int CNT_MAX  = 7,
  parameter int CNT_INIT = 2,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req_valid,
  input  logic [N_PORTS-1:0] req_op,
  output logic [N_PORTS-1:0] grant_o,
  output logic [N_PORTS-1:0] rel_done_o,
  output logic [N_PORTS-1:0] rel_err_o,
  output logic [N_PORTS-1:0] parked_o,
  output logic [CNT_W-1:0]   count_o
);

  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [N_PORTS-1:0] parked_q, grant_q, done_q, err_q;
  logic [N_PORTS-1:0] ack_q, cand;
  logic               req_hit, wake_hit;
  logic [IDX_W-1:0]   req_idx, wake_idx;
  logic               cnt_zero, cnt_full;
  sema_ev_e           ev;

  // Named internal events for the checks below.
  logic ev_take, ev_park, ev_handoff, ev_free, ev_ovfl;

  assign ack_q = grant_q | done_q | err_q;
  assign cand  = req_valid & ~parked_q & ~ack_q;

  sema_rr_pick #(.N(N_PORTS)) u_req_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cand),
    .advance (1'b1),
    .found   (req_hit),
    .idx     (req_idx)
  );

  sema_rr_pick #(.N(N_PORTS)) u_wake_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (parked_q),
    .advance (ev_handoff),
    .found   (wake_hit),
    .idx     (wake_idx)
  );

  assign ev = sema_classify(req_hit, sema_op_e'(req_op[req_idx]),
                            cnt_zero, wake_hit, cnt_full);

  assign ev_take    = (ev == EV_TAKE);
  assign ev_park    = (ev == EV_PARK);
  assign ev_handoff = (ev == EV_HANDOFF);
  assign ev_free    = (ev == EV_FREE);
  assign ev_ovfl    = (ev == EV_OVFL);

  sema_count_reg #(.CNT_MAX(CNT_MAX), .CNT_INIT(CNT_INIT)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .count   (count_o),
    .is_zero (cnt_zero),
    .is_full (cnt_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked_q <= '0;
      grant_q  <= '0;
      done_q   <= '0;
      err_q    <= '0;
    end else begin
      grant_q <= '0;
      done_q  <= '0;
      err_q   <= '0;
      if (ev_take) grant_q[req_idx] <= 1'b1;
      if (ev_park) parked_q[req_idx] <= 1'b1;
      if (ev_handoff) begin
        grant_q[wake_idx]  <= 1'b1;
        parked_q[wake_idx] <= 1'b0;
        done_q[req_idx]    <= 1'b1;
      end
      if (ev_free) done_q[req_idx] <= 1'b1;
      if (ev_ovfl) err_q[req_idx]  <= 1'b1;
    end
  end

  assign grant_o    = grant_q;
  assign rel_done_o = done_q;
  assign rel_err_o  = err_q;
  assign parked_o   = parked_q;

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  p_single_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done_q | err_q) <= 1);
  p_park_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_park |=> (grant_q == '0) && (parked_q != '0));
  p_handoff_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handoff |=> ($countones(grant_q) == 1) && ($countones(done_q) == 1));
  p_ovfl_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovfl |=> (err_q != '0) && (done_q == '0));
  p_wake_only_waiter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handoff |-> parked_q[wake_idx]);

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_port_chk
    p_waiter_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      parked_q[gi] |-> req_valid[gi]);
    p_grant_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q[gi] |=> !grant_q[gi]);
    p_parked_not_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      parked_q[gi] |-> !grant_q[gi]);
  end

endmodule

// File: tb/hw_sema_unit_tb.sv
`timescale 1ns/1ps
module hw_sema_unit_tb;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP-1:0] req_op = '0;
  logic [NP-1:0] grant_o, rel_done_o, rel_err_o, parked_o;
  logic [1:0]    count_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hw_sema_unit #(.N_PORTS(NP), .CNT_MAX(3), .CNT_INIT(1)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .grant_o    (grant_o),
    .rel_done_o (rel_done_o),
    .rel_err_o  (rel_err_o),
    .parked_o   (parked_o),
    .count_o    (count_o)
  );

  typedef struct packed {
    logic [3:0] vld;
    logic [3:0] op;
    logic [3:0] g;
    logic [3:0] d;
    logic [3:0] e;
    logic [1:0] cnt;
    logic [3:0] w;
  } row_t;

  // Inputs for one cycle, outputs expected after that cycle's edge.
  // Free-count limit 3, initial count 1.
  localparam row_t TBL [22] = '{
    {4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 2'd0, 4'b0000}, // p0 takes
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000},
    {4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0010}, // p1 parks
    {4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0110}, // p2 parks
    {4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0110},
    {4'b0111, 4'b0001, 4'b0010, 4'b0001, 4'b0000, 2'd0, 4'b0100}, // p0 hands to p1
    {4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0100},
    {4'b0110, 4'b0010, 4'b0100, 4'b0010, 4'b0000, 2'd0, 4'b0000}, // p1 hands to p2
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000},
    {4'b0100, 4'b0100, 4'b0000, 4'b0100, 4'b0000, 2'd1, 4'b0000}, // p2 frees
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd1, 4'b0000},
    {4'b1001, 4'b1001, 4'b0000, 4'b1000, 4'b0000, 2'd2, 4'b0000}, // p3 before p0
    {4'b0001, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 2'd3, 4'b0000},
    {4'b0010, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 2'd3, 4'b0000}, // overflow
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd3, 4'b0000},
    {4'b1111, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 2'd2, 4'b0000}, // four at once
    {4'b1011, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 2'd1, 4'b0000},
    {4'b0011, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 2'd0, 4'b0000},
    {4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0010},
    {4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0010},
    {4'b1010, 4'b1000, 4'b0010, 4'b1000, 4'b0000, 2'd0, 4'b0000}, // wake search wraps
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0, 4'b0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the run ended");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 count after reset", int'(count_o), 1);
    chk("R1 parked after reset", int'(parked_o), 0);
    chk("R1 pulses after reset", int'(grant_o | rel_done_o | rel_err_o), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 22; i++) begin
      req_valid = TBL[i].vld;
      req_op    = TBL[i].op;
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2 R3 R5 R6 R7 R9 grant row %0d", i), int'(grant_o), int'(TBL[i].g));
      chk($sformatf("R4 R5 R6 done row %0d", i), int'(rel_done_o), int'(TBL[i].d));
      chk($sformatf("R8 error row %0d", i), int'(rel_err_o), int'(TBL[i].e));
      chk($sformatf("R10 count row %0d", i), int'(count_o), int'(TBL[i].cnt));
      chk($sformatf("R3 R9 parked row %0d", i), int'(parked_o), int'(TBL[i].w));
    end

    // Reset in mid-run restores the initial state (R1).
    req_valid = 4'b0010;
    req_op    = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    chk("R3 p1 parked before reset", int'(parked_o), 2);
    rst_n = 1'b0;
    req_valid = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 count after mid-run reset", int'(count_o), 1);
    chk("R1 parked cleared by reset", int'(parked_o), 0);
    rst_n = 1'b1;

    // Only CNT_INIT holders at once (R10): pointer restarts at port 0 (R6).
    req_valid = 4'b1100;
    req_op    = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    chk("R6 first served after reset is p2", int'(grant_o), 4);
    chk("R10 count at zero", int'(count_o), 0);
    req_valid = 4'b1000;
    @(posedge clk);
    @(negedge clk);
    chk("R10 second acquirer not granted", int'(grant_o), 0);
    chk("R3 second acquirer parked", int'(parked_o), 8);
    chk("R10 count stays zero", int'(count_o), 0);
    req_valid = '0;

    finished = 1;
    report();
    $finish;
  end

endmodule